// File: doc/BRIEF.md
# Event Interrupt, Halt and Reset Controller

The block gathers completion, report and fault pulses from two bus masters, each running two command queues, into a single sticky 32-bit status word. A programmable enable mask selects which status bits drive the single interrupt line. Clearing takes two steps. Software first stages the bits it wants cleared, and a separate commit write then applies them. An event that arrives in the same cycle as the commit is never lost.

The same status word also reports the outcome of two control handshakes. A halt request to a master stays on its output line until that master reports idle. The idle indication means the master has finished its current bus byte. The following cycle posts a per-master halt acknowledge. A reset command drives a set of reset lines, limited to the legal reset pattern, for a fixed number of cycles. When the lines drop, a reset-done acknowledge is posted. Per-master error summaries are also provided, each formed as the OR of that master's error group in the status word.

Register access is a single-cycle write port with a combinational read mux. Word addresses: 0 status (read only), 1 enable mask, 2 clear stage, 3 clear commit, 4 halt request, 5 reset command.

Top module: `evt_irq_ctl`

## Requirements
- R1: Completion events set fixed status bits. Read done of master m sets bit 12m. The report of master m, queue q (input index 2m+q) sets bit 4+4q+12m.
- R2: Fault events set fixed status bits. The NACK of master m, queue q (index 2m+q) sets bit 27+2m+q. Fault input 8m+k, for k=0..7, sets bit P[k]+12m, with P = {1,2,5,6,7,9,10,11}.
- R3: Status bits stay set until cleared. Writes to the clear stage (address 2) OR into a readable stage register and do not change the status.
- R4: A write to address 3 with data bit 0 set clears every staged bit from the status and empties the stage. A write with bit 0 clear does nothing.
- R5: A status bit whose event arrives in the same cycle as the clear commit stays set.
- R6: irq is high exactly when some status bit is also set in the enable mask (address 1, readable).
- R7: mst_err[0] is high while any status bit in 0x18000EE6 is set. mst_err[1] is high while any bit in 0x60EE6000 is set. Non-error bits do not affect them.
- R8: Writing address 4 with data bit m set raises halt_req[m]. The request holds while mst_idle[m] is low. In the first cycle it sees idle, the request drops and status bit 25+m is set.
- R9: A reset command drives rst_lines = data & 0x0F73F3F7 for RST_HOLD cycles. The lines then drop, and status bit 24 is set on the same edge.
- R10: A reset command with no bit inside 0x0F73F3F7 is ignored. So is any reset command issued while a reset is in progress.
- R11: After reset, the status, mask, stage, halt requests, reset lines, irq and mst_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| ev_rd_done | input | 2 | Read-done pulse per master |
| ev_report | input | 4 | Queue report pulse, index 2m+q |
| ev_nack | input | 4 | NACK error pulse, index 2m+q |
| ev_fault | input | 16 | Other fault pulses, eight per master |
| mst_idle | input | 2 | Master has finished its current byte and is idle |
| halt_req | output | 2 | Halt request per master |
| rst_lines | output | 32 | Reset lines toward the masters |
| mst_err | output | 2 | Error-group summary per master |
| irq | output | 1 | Interrupt line |

## Verification
The event mapping is driven with several multi-bit pulse combinations. Each combination mixes masters and queues, so a swapped master or queue index shows up as a wrong bit position. Clearing is tried with partial and accumulated stages, with a commit write that has bit 0 low, and with an event that collides with the commit. These patterns separate a stage that does not accumulate, a clear that skips staging, and a clear that wins over a new event. The halt is tried both against a busy master and against one that is already idle. The reset is tried with a full pattern, a per-master pattern, an out-of-mask pattern and a command that overlaps a reset already running.

// File: rtl/evt_ctl_pkg.sv
package evt_ctl_pkg;

    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int NUM_MST  = 2;
    localparam int NUM_Q    = 2;
    localparam int FLT_PER  = 8;
    localparam int MST_STEP = 12;

    localparam int BIT_RST_DONE  = 24;
    localparam int BIT_HALT_ACK0 = 25;
    localparam int BIT_NACK0     = 27;

    localparam logic [DW-1:0] ERR_GRP0  = 32'h1800_0EE6;
    localparam logic [DW-1:0] ERR_GRP1  = 32'h60EE_6000;
    localparam logic [DW-1:0] RST_LEGAL = 32'h0F73_F3F7;

    typedef enum logic [AW-1:0] {
        A_STATUS = 3'd0,
        A_MASK   = 3'd1,
        A_STAGE  = 3'd2,
        A_COMMIT = 3'd3,
        A_HALT   = 3'd4,
        A_RESET  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_MST-1:0]         rd_done;
        logic [NUM_MST*NUM_Q-1:0]   report;
        logic [NUM_MST*NUM_Q-1:0]   nack;
        logic [NUM_MST*FLT_PER-1:0] fault;
    } evt_t;

    function automatic int fault_pos(input int k);
        case (k)
            0: return 1;
            1: return 2;
            2: return 5;
            3: return 6;
            4: return 7;
            5: return 9;
            6: return 10;
            default: return 11;
        endcase
    endfunction

    function automatic logic [DW-1:0] map_events(input evt_t e,
                                                 input logic [NUM_MST-1:0] hack,
                                                 input logic rdone);
        logic [DW-1:0] v;
        v = '0;
        for (int m = 0; m < NUM_MST; m++) begin
            v[MST_STEP*m] = e.rd_done[m];
            for (int q = 0; q < NUM_Q; q++) begin
                v[4 + 4*q + MST_STEP*m]   = e.report[NUM_Q*m+q];
                v[BIT_NACK0 + NUM_Q*m + q] = e.nack[NUM_Q*m+q];
            end
            for (int k = 0; k < FLT_PER; k++)
                v[fault_pos(k) + MST_STEP*m] = e.fault[FLT_PER*m+k];
            v[BIT_HALT_ACK0 + m] = hack[m];
        end
        v[BIT_RST_DONE] = rdone;
        return v;
    endfunction

endpackage

// File: rtl/evt_status.sv
module evt_status
    import evt_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_i,
    input  logic          stage_wr,
    input  logic          commit_i,
    input  logic          mask_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] stage_o,
    output logic [DW-1:0] mask_o,
    output logic          irq_o
);
    logic [DW-1:0] status_q, stage_q, mask_q, clr_vec;

    assign clr_vec = commit_i ? stage_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            stage_q  <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_i;
            if (commit_i)
                stage_q <= '0;
            else if (stage_wr)
                stage_q <= stage_q | wdata;
            if (mask_wr)
                mask_q <= wdata;
        end
    end

    assign status_o = status_q;
    assign stage_o  = stage_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(status_q & mask_q);

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((status_q & $past(set_i)) == $past(set_i))) else $error("event lost"); // R5

    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(commit_i) && !$past(stage_wr) |-> stage_q == $past(stage_q)) else $error("stage drift"); // R3
endmodule

// File: rtl/evt_halt.sv
module evt_halt
    import evt_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [NUM_MST-1:0] sel_i,
    input  logic [NUM_MST-1:0] idle_i,
    output logic [NUM_MST-1:0] req_o,
    output logic [NUM_MST-1:0] ack_o
);
    logic [NUM_MST-1:0] req_q;

    for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
        always_ff @(posedge clk) begin
            if (rst)
                req_q[m] <= 1'b0;
            else if (wr_i && sel_i[m])
                req_q[m] <= 1'b1;
            else if (idle_i[m])
                req_q[m] <= 1'b0;
        end

        assign ack_o[m] = req_q[m] && idle_i[m];

        AST_HALT_WAITS_IDLE: assert property (@(posedge clk) disable iff (rst)
            req_q[m] && !idle_i[m] |=> req_q[m]) else $error("halt dropped early"); // R8
    end

    assign req_o = req_q;
endmodule

// File: rtl/evt_reset.sv
module evt_reset
    import evt_ctl_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lines_o,
    output logic          done_o
);
    localparam int CW = $clog2(RST_HOLD + 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] lines_q;
    logic          accept;

    assign accept = wr_i && !active_q && (|(wdata & RST_LEGAL));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            lines_q  <= '0;
        end else if (accept) begin
            active_q <= 1'b1;
            cnt_q    <= CW'(RST_HOLD - 1);
            lines_q  <= wdata & RST_LEGAL;
        end else if (active_q) begin
            if (cnt_q == '0) begin
                active_q <= 1'b0;
                lines_q  <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign lines_o = lines_q;
    assign done_o  = active_q && (cnt_q == '0);

    AST_RST_LINES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (lines_q & ~RST_LEGAL) == '0) else $error("illegal reset line"); // R9

    AST_RST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done_o |=> lines_q == '0) else $error("lines stuck after done"); // R9
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
    import evt_ctl_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic [1:0]    ev_rd_done,
    input  logic [3:0]    ev_report,
    input  logic [3:0]    ev_nack,
    input  logic [15:0]   ev_fault,
    input  logic [1:0]    mst_idle,
    output logic [1:0]    halt_req,
    output logic [31:0]   rst_lines,
    output logic [1:0]    mst_err,
    output logic          irq
);
    evt_t          evts;
    logic [DW-1:0] set_vec, status, stage, mask;
    logic [1:0]    halt_ack;
    logic          rst_done;
    logic          wr_mask, wr_stage, wr_commit, wr_halt, wr_reset;

    assign evts = '{rd_done: ev_rd_done, report: ev_report, nack: ev_nack, fault: ev_fault};
    assign set_vec = map_events(evts, halt_ack, rst_done);

    assign wr_mask   = wr_en && (wr_addr == A_MASK);
    assign wr_stage  = wr_en && (wr_addr == A_STAGE);
    assign wr_commit = wr_en && (wr_addr == A_COMMIT) && wr_data[0];
    assign wr_halt   = wr_en && (wr_addr == A_HALT);
    assign wr_reset  = wr_en && (wr_addr == A_RESET);

    evt_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .stage_wr (wr_stage),
        .commit_i (wr_commit),
        .mask_wr  (wr_mask),
        .wdata    (wr_data),
        .status_o (status),
        .stage_o  (stage),
        .mask_o   (mask),
        .irq_o    (irq)
    );

    evt_halt u_halt (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr_halt),
        .sel_i  (wr_data[1:0]),
        .idle_i (mst_idle),
        .req_o  (halt_req),
        .ack_o  (halt_ack)
    );

    evt_reset #(.RST_HOLD(RST_HOLD)) u_reset (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_reset),
        .wdata   (wr_data),
        .lines_o (rst_lines),
        .done_o  (rst_done)
    );

    assign mst_err[0] = |(status & ERR_GRP0);
    assign mst_err[1] = |(status & ERR_GRP1);

    always_comb begin
        case (rd_addr)
            A_STATUS: rd_data = status;
            A_MASK:   rd_data = mask;
            A_STAGE:  rd_data = stage;
            A_HALT:   rd_data = {30'b0, halt_req};
            A_RESET:  rd_data = rst_lines;
            default:  rd_data = '0;
        endcase
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq) else $error("irq without enable"); // R6

    AST_ACK_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(status[BIT_HALT_ACK0]) |-> $past(halt_req[0]) && $past(mst_idle[0])) else $error("ack without idle"); // R8
endmodule

// File: tb/evt_irq_ctl_tb.sv
module evt_irq_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  ev_rd_done = '0;
    logic [3:0]  ev_report = '0;
    logic [3:0]  ev_nack = '0;
    logic [15:0] ev_fault = '0;
    logic [1:0]  mst_idle = '0;
    logic [1:0]  halt_req;
    logic [31:0] rst_lines;
    logic [1:0]  mst_err;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctl #(.RST_HOLD(HOLD)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_rd_done(ev_rd_done),
        .ev_report(ev_report), .ev_nack(ev_nack), .ev_fault(ev_fault),
        .mst_idle(mst_idle), .halt_req(halt_req), .rst_lines(rst_lines),
        .mst_err(mst_err), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [1:0] rdd, input logic [3:0] rep, input logic [3:0] nk, input logic [15:0] flt);
        @(negedge clk);
        ev_rd_done = rdd; ev_report = rep; ev_nack = nk; ev_fault = flt;
        @(negedge clk);
        ev_rd_done = '0; ev_report = '0; ev_nack = '0; ev_fault = '0;
    endtask

    task automatic clear_all();
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h1);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(3'd0, d); chk("R11", "status", d, 0);
        rd(3'd1, d); chk("R11", "mask", d, 0);
        rd(3'd2, d); chk("R11", "stage", d, 0);
        chk("R11", "halt_req", {30'b0, halt_req}, 0);
        chk("R11", "rst_lines", rst_lines, 0);
        chk("R11", "irq/mst_err", {29'b0, irq, mst_err}, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        pulse(2'b10, 4'b1000, 4'b0000, 16'h0000);
        rd(3'd0, d); chk("R1", "m1 rd_done + m1q1 report", d, 32'h0010_1000);
        clear_all();
        pulse(2'b01, 4'b0110, 4'b0000, 16'h0000);
        rd(3'd0, d); chk("R1", "m0 rd_done + m0q1 + m1q0", d, 32'h0001_0101);
        chk("R7", "non-error bits", {30'b0, mst_err}, 0);
        clear_all();
        pulse(2'b00, 4'b0000, 4'b1001, 16'h0101);
        rd(3'd0, d); chk("R2", "nack m0q0/m1q1 + fault k0", d, 32'h4800_2002);
        chk("R7", "both groups", {30'b0, mst_err}, 2'b11);
        clear_all();
        pulse(2'b00, 4'b0000, 4'b0000, 16'h8000);
        rd(3'd0, d); chk("R2", "m1 fault k7", d, 32'h0080_0000);
        chk("R7", "m1 group only", {30'b0, mst_err}, 2'b10);
        clear_all();
        pulse(2'b00, 4'b0000, 4'b0100, 16'h0020);
        rd(3'd0, d); chk("R2", "m1q0 nack + m0 fault k5", d, 32'h2000_0200);
        clear_all();
    endtask

    task automatic t_clear();
        logic [31:0] d;
        pulse(2'b11, 4'b0000, 4'b0000, 16'h0000);
        wr(3'd2, 32'h0000_1000);
        rd(3'd0, d); chk("R3", "staging leaves status", d, 32'h0000_1001);
        rd(3'd2, d); chk("R3", "stage readback", d, 32'h0000_1000);
        wr(3'd2, 32'h0000_0001);
        rd(3'd2, d); chk("R3", "stage accumulates", d, 32'h0000_1001);
        wr(3'd3, 32'h0000_0002);
        rd(3'd0, d); chk("R4", "commit bit0 low ignored", d, 32'h0000_1001);
        wr(3'd3, 32'h0000_0001);
        rd(3'd0, d); chk("R4", "commit clears", d, 0);
        rd(3'd2, d); chk("R4", "stage emptied", d, 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        pulse(2'b01, 4'b0001, 4'b0000, 16'h0000);
        wr(3'd2, 32'h0000_0011);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h1; ev_report = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ev_report = '0;
        rd(3'd0, d); chk("R5", "colliding event survives", d, 32'h0000_0010);
        clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] d;
        pulse(2'b00, 4'b0001, 4'b0000, 16'h0000);
        chk("R6", "irq masked", {31'b0, irq}, 0);
        wr(3'd1, 32'h0000_0010);
        chk("R6", "irq enabled", {31'b0, irq}, 1);
        rd(3'd1, d); chk("R6", "mask readback", d, 32'h0000_0010);
        wr(3'd1, 32'h0000_0100);
        chk("R6", "irq other bit", {31'b0, irq}, 0);
        wr(3'd1, 32'h0);
        clear_all();
    endtask

    task automatic t_halt();
        logic [31:0] d;
        mst_idle = 2'b00;
        wr(3'd4, 32'h1);
        chk("R8", "halt raised", {30'b0, halt_req}, 2'b01);
        repeat (3) @(negedge clk);
        chk("R8", "halt held while busy", {30'b0, halt_req}, 2'b01);
        rd(3'd0, d); chk("R8", "no ack while busy", d, 0);
        mst_idle = 2'b01;
        @(negedge clk);
        chk("R8", "halt dropped", {30'b0, halt_req}, 0);
        rd(3'd0, d); chk("R8", "m0 halt ack", d, 32'h0200_0000);
        mst_idle = 2'b11;
        wr(3'd4, 32'hFFFF_FFFE);
        chk("R8", "m1 halt raised", {30'b0, halt_req}, 2'b10);
        @(negedge clk);
        chk("R8", "m1 halt dropped", {30'b0, halt_req}, 0);
        rd(3'd0, d); chk("R8", "m1 halt ack", d, 32'h0600_0000);
        clear_all();
    endtask

    task automatic t_reset_cmd();
        logic [31:0] d;
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R9", "full reset lines", rst_lines, 32'h0F73_F3F7);
        repeat (HOLD - 1) @(negedge clk);
        chk("R9", "lines held", rst_lines, 32'h0F73_F3F7);
        rd(3'd0, d); chk("R9", "no done yet", d, 0);
        @(negedge clk);
        chk("R9", "lines dropped", rst_lines, 0);
        rd(3'd0, d); chk("R9", "reset done", d, 32'h0100_0000);
        clear_all();
        wr(3'd5, 32'h0000_03F1);
        chk("R9", "m0 reset lines", rst_lines, 32'h0000_03F1);
        wr(3'd5, 32'h0003_F001);
        chk("R10", "overlapping command ignored", rst_lines, 32'h0000_03F1);
        repeat (2*HOLD) @(negedge clk);
        chk("R9", "m0 reset over", rst_lines, 0);
        clear_all();
        wr(3'd5, 32'h8000_0008);
        chk("R10", "out-of-pattern lines", rst_lines, 0);
        repeat (HOLD + 2) @(negedge clk);
        rd(3'd0, d); chk("R10", "no done for ignored cmd", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_map();
        t_clear();
        t_same_cycle();
        t_irq();
        t_halt();
        t_reset_cmd();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule